// File: doc/BRIEF.md
# Dual-Slot Card Power Switch Controller

This block is the digital control part of a power switch that feeds two removable cards. A host controller sends a nine-bit control word over three wires: a data line, a shift clock and a load strobe. All three are sampled with the block's system clock. The block turns the loaded word into enables for twelve power switches. Each slot has a supply output and a programming output, and each output is fed by a group of three switches.

A supply output can be grounded, switched to 3.3 V, switched to 5 V, or left floating. A programming output can be grounded, tied to its own slot's supply, switched to 12 V, or left floating. The same word also holds an active-low shutdown bit. Two card-reset pins of opposite polarity force every output to ground, and the outputs stay grounded until the host loads a fresh word. A thermal-fault input opens every switch. Each output has its own overcurrent input, which opens only that output, and any overcurrent pulls down a shared fault flag.

Whenever an output changes from one closed switch to another, the block first opens the whole group for a programmable gap. Two switches feeding the same output are therefore never closed together.

Top module: `dslot_pwr_ctrl`

## Requirements
- R1: On each rising edge of `ser_clk`, the block shifts `ser_data` into a nine-bit register. The first bit shifted becomes D8 and the last becomes D0. On a rising edge of `ser_latch`, the shifted word becomes the active control word.
- R2: `sw_en` is arranged as four groups of three bits. Bits [2:0] feed the slot A supply, [5:3] the slot A programming output, [8:6] the slot B supply and [11:9] the slot B programming output. For the slot A supply, D3 selects 3.3 V and D2 selects 5 V. Within a supply group, bit 0 is ground, bit 1 is 3.3 V and bit 2 is 5 V. If exactly one select bit is set, that voltage's switch closes. If the two bits are equal, the ground switch closes.
- R3: The slot B supply decodes the same way as R2, with D6 selecting 3.3 V and D7 selecting 5 V.
- R4: Within a programming group, bit 0 is ground, bit 1 is follow-supply and bit 2 is 12 V. For slot A the pair is (D0, D1); for slot B it is (D4, D5). Pair 00 grounds the output, 01 ties it to the slot's supply, 10 selects 12 V and 11 leaves every switch of the group open.
- R5: When the active word has D8 = 0 and no card reset is in force, all twelve switches open and `low_power` is 1, whatever the other bits hold. Otherwise `low_power` is 0.
- R6: While `card_rst_hi` is 1 or `card_rst_lo_n` is 0, only the four ground switches (mask 0x249) may be closed. Once any gap from R10 has elapsed, exactly those four are closed.
- R7: A `ser_latch` edge seen while a card reset is in force is ignored. After the reset is released, the outputs stay at the ground mask until a new word is loaded.
- R8: While `thermal_fault` is 1, `sw_en` is 0 from the next cycle on. When the fault clears, the decoded word is applied again.
- R9: `oc_in[g]` opens only group g, with the same group order as `sw_en`, while normal decoding is active. `oc_flag_n` is registered and goes to 0 one cycle after any `oc_in` bit is 1, and back to 1 one cycle after all are 0.
- R10: When a group moves from a closed switch to any different selection, it stays fully open for DEAD_CYC+1 cycles before the new switch closes. No group ever has more than one switch closed.
- R11: After `rst_n` is released, the four ground switches close on the first clock edge. `low_power` is 0 and `oc_flag_n` is 1.
- R12: A group that is fully open with no gap pending takes its new selection one clock edge after the control word or condition changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| ser_data | input | 1 | Serial data bit |
| ser_clk | input | 1 | Serial shift clock; its rising edge shifts in a bit |
| ser_latch | input | 1 | Load strobe; its rising edge loads the shifted word |
| card_rst_hi | input | 1 | Card reset, active high |
| card_rst_lo_n | input | 1 | Card reset, active low |
| thermal_fault | input | 1 | Over-temperature condition; opens all switches |
| oc_in | input | 4 | Per-output overcurrent: A supply, A programming, B supply, B programming |
| sw_en | output | 12 | Switch enables, three per output group, bit 0 of each group is ground |
| low_power | output | 1 | High while the shutdown bit of the active word is 0 |
| oc_flag_n | output | 1 | Low while any output reports overcurrent |

## Verification
A load strobe and the break-before-make sequencer can act in the same cycle. A new word arrives while a group still holds its old switch, so the decoder's target changes on the very edge at which the sequencer must open the group. The bench loads a word that changes only the slot A supply. It then compares the outputs on each of the following cycles: the slot A supply group must read zero for exactly the gap length while the other three groups stay untouched, and only then may the new switch appear. A second collision is a load strobe during a card reset. It is judged by showing, once the reset is released, that the outputs still sit at the ground mask and `low_power` stays low, even though the word that was ignored had the shutdown bit cleared.

// File: rtl/dslot_pwr_pkg.sv
package dslot_pwr_pkg;
  localparam int WORD_W   = 9;
  localparam int GRP_W    = 3;
  localparam int N_GRP    = 4;
  localparam int SW_W     = GRP_W * N_GRP;
  localparam logic [SW_W-1:0] GND_MASK = 12'h249;

  typedef logic [GRP_W-1:0] grp_t;

  // Supply group: bit0 ground, bit1 3.3 V, bit2 5 V.
  function automatic grp_t supply_pick(input logic sel33, input logic sel5);
    grp_t r;
    if (sel33 == sel5) r = 3'b001;
    else if (sel33)    r = 3'b010;
    else               r = 3'b100;
    return r;
  endfunction

  // Programming group: bit0 ground, bit1 follow supply, bit2 12 V.
  function automatic grp_t prog_pick(input logic hi_sel, input logic follow);
    grp_t r;
    unique case ({hi_sel, follow})
      2'b00:   r = 3'b001;
      2'b01:   r = 3'b010;
      2'b10:   r = 3'b100;
      default: r = 3'b000;
    endcase
    return r;
  endfunction

  function automatic logic [SW_W-1:0] word_to_switches(input logic [WORD_W-1:0] w);
    return {prog_pick(w[4], w[5]), supply_pick(w[6], w[7]),
            prog_pick(w[0], w[1]), supply_pick(w[3], w[2])};
  endfunction
endpackage

// File: rtl/dslot_serial_rx.sv
module dslot_serial_rx
  import dslot_pwr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_data,
  input  logic              ser_clk,
  input  logic              ser_latch,
  input  logic              card_rst,
  output logic [WORD_W-1:0] ctrl,
  output logic              armed,
  output logic              shift_evt,
  output logic              latch_evt
);
  logic              sclk_d, slat_d;
  logic [WORD_W-1:0] shreg;

  assign shift_evt = ser_clk & ~sclk_d;
  assign latch_evt = ser_latch & ~slat_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      slat_d <= 1'b0;
      shreg  <= '0;
      ctrl   <= '0;
      armed  <= 1'b0;
    end else begin
      sclk_d <= ser_clk;
      slat_d <= ser_latch;
      if (shift_evt) shreg <= {shreg[WORD_W-2:0], ser_data};
      if (card_rst) begin
        armed <= 1'b0;
      end else if (latch_evt) begin
        ctrl  <= shreg;
        armed <= 1'b1;
      end
    end
  end

  // R1: a load edge outside reset copies the shifted word
  a_r1_load_word: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_evt && !card_rst) |=> (armed && ctrl == $past(shreg)));
  // R7: card reset disarms and freezes the control word
  a_r7_reset_blocks_load: assert property (@(posedge clk) disable iff (!rst_n)
    card_rst |=> (!armed && $stable(ctrl)));
endmodule

// File: rtl/dslot_target.sv
module dslot_target
  import dslot_pwr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] ctrl,
  input  logic              armed,
  input  logic              card_rst,
  input  logic              thermal_fault,
  input  logic [N_GRP-1:0]  oc_in,
  output logic [SW_W-1:0]   target,
  output logic              low_power
);
  logic [SW_W-1:0] decoded, run_tgt;
  logic            forced_gnd;

  assign decoded    = word_to_switches(ctrl);
  assign forced_gnd = card_rst | ~armed;
  assign low_power  = ~forced_gnd & ~ctrl[WORD_W-1];

  for (genvar g = 0; g < N_GRP; g++) begin : g_oc
    assign run_tgt[g*GRP_W +: GRP_W] = oc_in[g] ? '0 : decoded[g*GRP_W +: GRP_W];
  end

  always_comb begin
    if (thermal_fault)          target = '0;
    else if (forced_gnd)        target = GND_MASK;
    else if (!ctrl[WORD_W-1])   target = '0;
    else                        target = run_tgt;
  end

  // R5: shutdown indication never coexists with a requested closed switch
  a_r5_lowpower_open: assert property (@(posedge clk) disable iff (!rst_n)
    low_power |-> (target == '0));
  // R6: forced grounding requests nothing but ground switches
  a_r6_ground_only: assert property (@(posedge clk) disable iff (!rst_n)
    forced_gnd |-> ((target & ~GND_MASK) == '0));
endmodule

// File: rtl/dslot_bbm.sv
module dslot_bbm
  import dslot_pwr_pkg::*;
#(
  parameter int DEAD_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  grp_t target,
  output grp_t q,
  output logic gap_active
);
  localparam int CW = (DEAD_CYC > 0) ? $clog2(DEAD_CYC + 1) : 1;
  logic [CW-1:0] cnt;

  assign gap_active = (cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q   <= '0;
      cnt <= '0;
    end else if (gap_active) begin
      cnt <= cnt - 1'b1;
    end else if (target != q) begin
      if (q != '0) begin
        q   <= '0;
        cnt <= CW'(DEAD_CYC);
      end else begin
        q <= target;
      end
    end
  end

  // R10: never two switches of one group closed
  a_r10_single_closed: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(q) <= 1);
  // R10: no direct hop between two different closed selections
  a_r10_no_direct_hop: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(q) != '0 && q != '0) |-> (q == $past(q)));
  // R10: while the gap counter runs the group stays open
  a_r10_gap_open: assert property (@(posedge clk) disable iff (!rst_n)
    gap_active |=> (q == '0));
endmodule

// File: rtl/dslot_pwr_ctrl.sv
module dslot_pwr_ctrl
  import dslot_pwr_pkg::*;
#(
  parameter int DEAD_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_data,
  input  logic              ser_clk,
  input  logic              ser_latch,
  input  logic              card_rst_hi,
  input  logic              card_rst_lo_n,
  input  logic              thermal_fault,
  input  logic [N_GRP-1:0]  oc_in,
  output logic [SW_W-1:0]   sw_en,
  output logic              low_power,
  output logic              oc_flag_n
);
  logic              card_rst;
  logic [WORD_W-1:0] ctrl;
  logic              armed, shift_evt, latch_evt;
  logic [SW_W-1:0]   target;
  logic [N_GRP-1:0]  gap_active;

  assign card_rst = card_rst_hi | ~card_rst_lo_n;

  dslot_serial_rx u_rx (
    .clk(clk), .rst_n(rst_n), .ser_data(ser_data), .ser_clk(ser_clk),
    .ser_latch(ser_latch), .card_rst(card_rst), .ctrl(ctrl), .armed(armed),
    .shift_evt(shift_evt), .latch_evt(latch_evt)
  );

  dslot_target u_tgt (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .armed(armed), .card_rst(card_rst),
    .thermal_fault(thermal_fault), .oc_in(oc_in), .target(target),
    .low_power(low_power)
  );

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    dslot_bbm #(.DEAD_CYC(DEAD_CYC)) u_bbm (
      .clk(clk), .rst_n(rst_n),
      .target(target[g*GRP_W +: GRP_W]),
      .q(sw_en[g*GRP_W +: GRP_W]),
      .gap_active(gap_active[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) oc_flag_n <= 1'b1;
    else        oc_flag_n <= ~(|oc_in);
  end

  // R8: thermal fault opens every switch on the next edge
  a_r8_thermal_open: assert property (@(posedge clk) disable iff (!rst_n)
    thermal_fault |=> (sw_en == '0));
  // R6: card reset leaves only ground switches closed
  a_r6_reset_ground: assert property (@(posedge clk) disable iff (!rst_n)
    card_rst |=> ((sw_en & ~GND_MASK) == '0));
  // R9: any overcurrent pulls the flag low next cycle
  a_r9_flag_low: assert property (@(posedge clk) disable iff (!rst_n)
    (|oc_in) |=> !oc_flag_n);
  // R5: shutdown state opens all switches
  a_r5_shutdown_open: assert property (@(posedge clk) disable iff (!rst_n)
    low_power |=> (sw_en == '0));
endmodule

// File: tb/dslot_pwr_ctrl_test.sv
`timescale 1ns/100ps
module dslot_pwr_ctrl_test;
  localparam int DEAD = 4;
  localparam logic [11:0] GND = 12'h249;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_data = 1'b0, ser_clk = 1'b0, ser_latch = 1'b0;
  logic card_rst_hi = 1'b0, card_rst_lo_n = 1'b1, thermal_fault = 1'b0;
  logic [3:0] oc_in = '0;
  logic [11:0] sw_en;
  logic low_power, oc_flag_n;

  int runs = 0;
  int fails = 0;
  bit done = 0;

  typedef struct {
    string       req;
    logic [11:0] sw;
    logic        lp;
    logic        ocn;
  } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  dslot_pwr_ctrl #(.DEAD_CYC(DEAD)) uut (
    .clk(clk), .rst_n(rst_n), .ser_data(ser_data), .ser_clk(ser_clk),
    .ser_latch(ser_latch), .card_rst_hi(card_rst_hi), .card_rst_lo_n(card_rst_lo_n),
    .thermal_fault(thermal_fault), .oc_in(oc_in), .sw_en(sw_en),
    .low_power(low_power), .oc_flag_n(oc_flag_n)
  );

  function automatic logic [2:0] m_sup(input logic v33, input logic v5);
    case ({v33, v5})
      2'b10:   return 3'b010;
      2'b01:   return 3'b100;
      default: return 3'b001;
    endcase
  endfunction

  function automatic logic [2:0] m_prg(input logic p12, input logic fol);
    case ({p12, fol})
      2'b00:   return 3'b001;
      2'b01:   return 3'b010;
      2'b10:   return 3'b100;
      default: return 3'b000;
    endcase
  endfunction

  function automatic logic [11:0] model(input logic [8:0] w);
    if (!w[8]) return 12'h000;
    return {m_prg(w[4], w[5]), m_sup(w[6], w[7]), m_prg(w[0], w[1]), m_sup(w[3], w[2])};
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic expect_out(input string req, input logic [11:0] sw,
                            input logic lp, input logic ocn);
    exp_t e;
    e.req = req; e.sw = sw; e.lp = lp; e.ocn = ocn;
    sb.push_back(e);
    tick(1);
  endtask

  task automatic send_bits(input logic [8:0] w);
    for (int i = 8; i >= 0; i--) begin
      ser_data = w[i];
      ser_clk = 1'b1;
      tick(1);
      ser_clk = 1'b0;
      tick(1);
    end
  endtask

  task automatic do_latch();
    ser_latch = 1'b1;
    tick(1);
    ser_latch = 1'b0;
  endtask

  task automatic load(input logic [8:0] w);
    send_bits(w);
    do_latch();
  endtask

  // monitor: compare queued expectations against the outputs
  initial begin
    forever begin
      @(negedge clk);
      #0.5;
      while (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        runs++;
        if (sw_en !== e.sw || low_power !== e.lp || oc_flag_n !== e.ocn) begin
          fails++;
          $display("FAIL %s: sw_en=%h lp=%b ocn=%b expected sw_en=%h lp=%b ocn=%b",
                   e.req, sw_en, low_power, oc_flag_n, e.sw, e.lp, e.ocn);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("[TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(2);
    expect_out("R11 power-up grounds", GND, 1'b0, 1'b1);

    // R1 R2 R3 R4: A 3.3 V, A follow, B 5 V, B 12 V
    load(9'h19A);
    tick(10);
    expect_out("R1 R2 R3 R4 first word", model(9'h19A), 1'b0, 1'b1);
    if (model(9'h19A) != 12'h912) $display("bench model mismatch");

    // R10: change only the slot A supply to 5 V, watch the gap
    send_bits(9'h196);
    do_latch();
    for (int k = 0; k < DEAD + 1; k++)
      expect_out("R10 gap open", model(9'h196) & ~12'h007, 1'b0, 1'b1);
    expect_out("R10 new switch after gap", model(9'h196), 1'b0, 1'b1);

    // R2 R4: equal supply bits ground, programming pair 11 floats
    load(9'h19F);
    tick(10);
    expect_out("R2 R4 equal bits and float", model(9'h19F), 1'b0, 1'b1);

    // R5: shutdown bit cleared
    load(9'h09A);
    tick(10);
    expect_out("R5 shutdown", 12'h000, 1'b1, 1'b1);

    // R12: from fully open, new word closes one edge after the load
    load(9'h19A);
    expect_out("R12 one-edge latency", model(9'h19A), 1'b0, 1'b1);
    tick(8);

    // R6 R7: active-high reset, load during reset ignored
    card_rst_hi = 1'b1;
    tick(10);
    expect_out("R6 active-high reset grounds", GND, 1'b0, 1'b1);
    load(9'h000);
    tick(2);
    card_rst_hi = 1'b0;
    tick(10);
    expect_out("R7 ground held, load in reset ignored", GND, 1'b0, 1'b1);
    load(9'h165);
    tick(10);
    expect_out("R7 R3 new word after release", model(9'h165), 1'b0, 1'b1);

    // R6: active-low reset
    card_rst_lo_n = 1'b0;
    tick(10);
    expect_out("R6 active-low reset grounds", GND, 1'b0, 1'b1);
    card_rst_lo_n = 1'b1;
    tick(6);
    expect_out("R7 still grounded after release", GND, 1'b0, 1'b1);
    load(9'h19A);
    tick(10);
    expect_out("R7 reload", model(9'h19A), 1'b0, 1'b1);

    // R8: thermal fault
    thermal_fault = 1'b1;
    expect_out("R8 thermal opens next edge", 12'h000, 1'b0, 1'b1);
    tick(4);
    expect_out("R8 thermal holds", 12'h000, 1'b0, 1'b1);
    thermal_fault = 1'b0;
    tick(10);
    expect_out("R8 recovery", model(9'h19A), 1'b0, 1'b1);

    // R9: overcurrent on slot A programming output
    oc_in = 4'b0010;
    expect_out("R9 overcurrent isolates group", model(9'h19A) & ~12'h038, 1'b0, 1'b0);
    oc_in = 4'b0000;
    expect_out("R9 flag releases", model(9'h19A) & ~12'h038, 1'b0, 1'b1);
    tick(10);
    expect_out("R9 group restored", model(9'h19A), 1'b0, 1'b1);
    oc_in = 4'b1000;
    expect_out("R9 slot B programming isolated", model(9'h19A) & ~12'hE00, 1'b0, 1'b0);
    oc_in = 4'b0000;
    tick(10);

    tick(2);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule